// File: doc/BRIEF.md
# Converter Result Byte Read-Out

This block is the parallel read-out port of a 15-bit sign-magnitude converter. A result arrives as 15 magnitude bits, a polarity flag (1 = positive input) and an overrange flag. When the converter's busy signal falls, the block latches that result into a holding register. A host then reads it one byte at a time over an 8-bit bus. The bus is gated by an active-low chip enable and an active-low read strobe. The tri-state pins are modelled as a data-out bus plus an output-enable signal.

Two read styles are supported. In demand mode, two steering inputs pick the byte: `byte_lo` selects the low magnitude byte, and `sel_ovr` chooses which flag sits in bit 7 of the high byte. In continuous mode the steering inputs are ignored. An internal sequencer, started by the busy fall, steps through three bytes, one per read-strobe release:
1. high byte with polarity,
2. low byte,
3. high byte with overrange.

All three reads must finish inside a window of 887 half clock cycles. If they do not, a timeout flag rises. All inputs are synchronous to `clk`, and reset is synchronous and active high.

Top module: `adc_readout_bus`

## Requirements
- R1: `data_oe` is 1 only while `ce_n`=0 and `rd_n`=0; whenever `data_oe` is 0, `data_out` is 8'h00.
- R2: In demand mode (`cont_mode`=0), with `byte_lo`=0 and `sel_ovr`=0, the bus carries {polarity, magnitude[14:8]} (bit 7 = polarity).
- R3: In demand mode, with `byte_lo`=0 and `sel_ovr`=1, the bus carries {overrange, magnitude[14:8]}.
- R4: In demand mode, with `byte_lo`=1, the bus carries magnitude[7:0] for either value of `sel_ovr`.
- R5: In continuous mode the byte order after a busy fall is fixed: {polarity, mag[14:8]}, then mag[7:0], then {overrange, mag[14:8]}. `byte_lo` and `sel_ovr` have no effect.
- R6: The sequencer advances on the clock edge where `rd_n` is seen high after a cycle with `ce_n`=0 and `rd_n`=0. `ce_n` may stay low across all reads. A strobe given while `ce_n`=1 does not advance it.
- R7: `win_timeout` rises if the third read has not completed by the 445th clock edge after the edge that saw busy fall (the 887 half-cycle window). It stays high until the next busy fall, which clears it.
- R8: `xfer_done` is a one-cycle pulse after the third continuous read. Once the sequence is finished or has timed out, continuous reads return {polarity, mag[14:8]}.
- R9: A busy fall (1 then 0 on consecutive edges) captures the result inputs. The holding register never changes while the bus is enabled; a capture that arrives during a read is applied once the bus is released.
- R10: After reset, `data_oe`, `data_out`, `xfer_done` and `win_timeout` are 0, and the holding register is zero.
- R11: Extended-overrange results are passed through unchanged. For example, at full scale (magnitude 0, overrange 1) the low byte reads 8'h00 and the high byte reads 8'h80 with `sel_ovr`=1; at 99 counts above full scale the low byte reads 8'h63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy | input | 1 | Converter busy; its fall latches a result |
| res_mag | input | 15 | Result magnitude |
| res_pos | input | 1 | Result polarity, 1 = positive |
| res_ovr | input | 1 | Result overrange flag |
| ce_n | input | 1 | Chip enable, active low |
| rd_n | input | 1 | Read strobe, active low |
| cont_mode | input | 1 | 1 = continuous sequence, 0 = demand steering |
| byte_lo | input | 1 | Demand mode: 1 = low byte |
| sel_ovr | input | 1 | Demand mode: 1 = overrange in bit 7 of high byte |
| data_out | output | 8 | Read-out byte |
| data_oe | output | 1 | Bus drive enable |
| xfer_done | output | 1 | One-cycle pulse after third continuous read |
| win_timeout | output | 1 | Read window expired before the third read |

## Verification
Four properties are checked on every cycle:
- bus gating by the two selects,
- stability of the holding register while the bus is driven,
- the window counter staying within its bound,
- the done pulse following only the last sequence step and never coinciding with a timeout.

Byte content under each steering combination, the fixed continuous order with the steering pins toggled, the window length and its clearing, and the deferral of a capture during a read can only be shown by the bench's scenarios.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int MAG_W  = 15;
    localparam int BYTE_W = 8;
    localparam int HI_W   = MAG_W - BYTE_W;

    typedef struct packed {
        logic [MAG_W-1:0] mag;
        logic             pos;
        logic             ovr;
    } conv_result_t;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_HI_POL = 2'd1,
        SEQ_LO     = 2'd2,
        SEQ_HI_OVR = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        PICK_HI_POL = 2'd0,
        PICK_HI_OVR = 2'd1,
        PICK_LO     = 2'd2
    } byte_pick_t;

    function automatic logic [BYTE_W-1:0] form_byte(conv_result_t r, byte_pick_t p);
        logic [BYTE_W-1:0] b;
        case (p)
            PICK_LO:     b = r.mag[BYTE_W-1:0];
            PICK_HI_OVR: b = {r.ovr, r.mag[MAG_W-1:BYTE_W]};
            default:     b = {r.pos, r.mag[MAG_W-1:BYTE_W]};
        endcase
        return b;
    endfunction

endpackage

// File: rtl/adc_rd_hold.sv
module adc_rd_hold
    import adc_rd_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         busy,
    input  conv_result_t res_in,
    input  logic         bus_on,
    output logic         busy_fall,
    output conv_result_t hold
);

    logic         busy_q;
    logic         pend;
    conv_result_t stage;

    assign busy_fall = busy_q & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            pend   <= 1'b0;
            stage  <= '0;
            hold   <= '0;
        end else begin
            busy_q <= busy;
            if (busy_fall) begin
                stage <= res_in;
                pend  <= 1'b1;
            end else if (pend && !bus_on) begin
                hold <= stage;
                pend <= 1'b0;
            end
        end
    end

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_on && $past(bus_on)) |-> $stable(hold));

    // R9
    stage_capture_chk: assert property (@(posedge clk) disable iff (rst)
        busy_fall |=> (stage == $past(res_in)));

endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
    import adc_rd_pkg::*;
#(
    parameter int WIN_HALF = 887
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       busy_fall,
    input  logic       ce_n,
    input  logic       rd_n,
    output seq_state_t state,
    output logic       done,
    output logic       timeout
);

    localparam int TMR_W = $clog2(WIN_HALF + 2);
    localparam logic [TMR_W-1:0] WIN_L  = TMR_W'(WIN_HALF);
    localparam logic [TMR_W-1:0] STEP_L = TMR_W'(2);

    logic [TMR_W-1:0] tmr;
    logic             rd_act_q;
    logic             rd_rise;

    assign rd_rise = rd_act_q & rd_n & ~ce_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_act_q <= 1'b0;
            state    <= SEQ_IDLE;
            tmr      <= '0;
            done     <= 1'b0;
            timeout  <= 1'b0;
        end else begin
            rd_act_q <= ~ce_n & ~rd_n;
            done     <= 1'b0;
            if (busy_fall) begin
                state   <= SEQ_HI_POL;
                tmr     <= '0;
                timeout <= 1'b0;
            end else if (state != SEQ_IDLE) begin
                if (tmr >= WIN_L) begin
                    state   <= SEQ_IDLE;
                    timeout <= 1'b1;
                end else begin
                    tmr <= tmr + STEP_L;
                    if (rd_rise) begin
                        case (state)
                            SEQ_HI_POL: state <= SEQ_LO;
                            SEQ_LO:     state <= SEQ_HI_OVR;
                            default: begin
                                state <= SEQ_IDLE;
                                done  <= 1'b1;
                            end
                        endcase
                    end
                end
            end
        end
    end

    // R7
    tmr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        tmr <= WIN_L + TMR_W'(1));

    // R8
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (state == SEQ_IDLE && $past(state) == SEQ_HI_OVR));

    // R8
    done_vs_timeout_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && timeout));

endmodule

// File: rtl/adc_rd_mux.sv
module adc_rd_mux
    import adc_rd_pkg::*;
(
    input  logic              ce_n,
    input  logic              rd_n,
    input  logic              cont_mode,
    input  logic              byte_lo,
    input  logic              sel_ovr,
    input  seq_state_t        state,
    input  conv_result_t      hold,
    output logic [BYTE_W-1:0] data_out,
    output logic              data_oe
);

    byte_pick_t pick;

    always_comb begin
        if (cont_mode) begin
            case (state)
                SEQ_LO:     pick = PICK_LO;
                SEQ_HI_OVR: pick = PICK_HI_OVR;
                default:    pick = PICK_HI_POL;
            endcase
        end else if (byte_lo) begin
            pick = PICK_LO;
        end else if (sel_ovr) begin
            pick = PICK_HI_OVR;
        end else begin
            pick = PICK_HI_POL;
        end
    end

    assign data_oe  = ~ce_n & ~rd_n;
    assign data_out = data_oe ? form_byte(hold, pick) : '0;

endmodule

// File: rtl/adc_readout_bus.sv
module adc_readout_bus
    import adc_rd_pkg::*;
#(
    parameter int WIN_HALF = 887
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic [MAG_W-1:0]  res_mag,
    input  logic              res_pos,
    input  logic              res_ovr,
    input  logic              ce_n,
    input  logic              rd_n,
    input  logic              cont_mode,
    input  logic              byte_lo,
    input  logic              sel_ovr,
    output logic [BYTE_W-1:0] data_out,
    output logic              data_oe,
    output logic              xfer_done,
    output logic              win_timeout
);

    conv_result_t res_in;
    conv_result_t hold;
    seq_state_t   state;
    logic         busy_fall;

    assign res_in = '{mag: res_mag, pos: res_pos, ovr: res_ovr};

    adc_rd_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .res_in    (res_in),
        .bus_on    (data_oe),
        .busy_fall (busy_fall),
        .hold      (hold)
    );

    adc_rd_seq #(.WIN_HALF(WIN_HALF)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .busy_fall (busy_fall),
        .ce_n      (ce_n),
        .rd_n      (rd_n),
        .state     (state),
        .done      (xfer_done),
        .timeout   (win_timeout)
    );

    adc_rd_mux u_mux (
        .ce_n      (ce_n),
        .rd_n      (rd_n),
        .cont_mode (cont_mode),
        .byte_lo   (byte_lo),
        .sel_ovr   (sel_ovr),
        .state     (state),
        .hold      (hold),
        .data_out  (data_out),
        .data_oe   (data_oe)
    );

    // R1
    bus_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (ce_n || rd_n) |-> (!data_oe && data_out == '0));

endmodule

// File: tb/adc_readout_bus_tb.sv
module adc_readout_bus_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        busy;
    logic [14:0] res_mag;
    logic        res_pos, res_ovr;
    logic        ce_n, rd_n, cont_mode, byte_lo, sel_ovr;
    logic [7:0]  data_out;
    logic        data_oe, xfer_done, win_timeout;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #2 clk = ~clk;

    adc_readout_bus u_dut (
        .clk(clk), .rst(rst), .busy(busy), .res_mag(res_mag), .res_pos(res_pos),
        .res_ovr(res_ovr), .ce_n(ce_n), .rd_n(rd_n), .cont_mode(cont_mode),
        .byte_lo(byte_lo), .sel_ovr(sel_ovr), .data_out(data_out),
        .data_oe(data_oe), .xfer_done(xfer_done), .win_timeout(win_timeout)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [14:0] mag;
        logic        pos;
        logic        ovr;
        logic        lo;
        logic        so;
        logic [7:0]  exp_b;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{4'd2,  15'h5A3C, 1'b1, 1'b0, 1'b0, 1'b0, 8'hDA},  // R2
        '{4'd3,  15'h5A3C, 1'b1, 1'b0, 1'b0, 1'b1, 8'h5A},  // R3
        '{4'd4,  15'h5A3C, 1'b1, 1'b0, 1'b1, 1'b0, 8'h3C},  // R4
        '{4'd4,  15'h5A3C, 1'b1, 1'b0, 1'b1, 1'b1, 8'h3C},  // R4
        '{4'd2,  15'h7FFF, 1'b0, 1'b0, 1'b0, 1'b0, 8'h7F},  // R2
        '{4'd3,  15'h7FFF, 1'b0, 1'b0, 1'b0, 1'b1, 8'h7F},  // R3
        '{4'd11, 15'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 8'h80},  // R11
        '{4'd11, 15'h0000, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00},  // R11
        '{4'd11, 15'd99,   1'b1, 1'b1, 1'b1, 1'b1, 8'h63},  // R11
        '{4'd11, 15'd99,   1'b1, 1'b1, 1'b0, 1'b0, 8'h80}   // R11
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load(input logic [14:0] m, input logic p, input logic o);
        @(negedge clk);
        res_mag = m; res_pos = p; res_ovr = o; busy = 1'b1;
        @(negedge clk);
        busy = 1'b0;
        idle(3);
    endtask

    task automatic rd_byte(input string req, input logic [7:0] exp_v);
        @(negedge clk);
        rd_n = 1'b0;
        #1 chk(req, data_out, exp_v);
        chk(req, {7'd0, data_oe}, 8'd1);
        @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; busy = 1'b0; res_mag = '0; res_pos = 1'b0; res_ovr = 1'b0;
        ce_n = 1'b1; rd_n = 1'b1; cont_mode = 1'b0; byte_lo = 1'b0; sel_ovr = 1'b0;
        idle(3);
        rst = 1'b0;
        idle(2);
        // R10 reset state
        chk("R10", data_out, 8'h00);
        chk("R10", {7'd0, data_oe}, 8'd0);
        chk("R10", {6'd0, xfer_done, win_timeout}, 8'd0);
        ce_n = 1'b0; rd_n = 1'b0;
        #1 chk("R10", data_out, 8'h00);
        @(negedge clk);
        // R1 gating: one select inactive
        ce_n = 1'b1;
        #1 chk("R1", {data_oe, data_out[6:0]}, 8'h00);
        ce_n = 1'b0; rd_n = 1'b1;
        #1 chk("R1", {data_oe, data_out[6:0]}, 8'h00);
        ce_n = 1'b1;

        // demand-mode vector walk (R2 R3 R4 R11)
        for (int i = 0; i < NV; i++) begin
            load(VECS[i].mag, VECS[i].pos, VECS[i].ovr);
            byte_lo = VECS[i].lo; sel_ovr = VECS[i].so; ce_n = 1'b0;
            rd_byte($sformatf("R%0d", VECS[i].req), VECS[i].exp_b);
            ce_n = 1'b1;
        end

        // R5 R6 R8 continuous sequence, steering toggled, ce_n held low
        cont_mode = 1'b1; byte_lo = 1'b1; sel_ovr = 1'b1;
        load(15'h1234, 1'b0, 1'b1);
        // R6: strobe with ce_n high must not advance
        @(negedge clk); rd_n = 1'b0;
        @(negedge clk); rd_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b0;
        rd_byte("R6", 8'h12);
        byte_lo = 1'b0; sel_ovr = 1'b0;
        rd_byte("R5", 8'h34);
        byte_lo = 1'b1;
        rd_byte("R5", 8'h92);
        chk("R8", {7'd0, xfer_done}, 8'd1);
        @(negedge clk);
        chk("R8", {7'd0, xfer_done}, 8'd0);
        chk("R7", {7'd0, win_timeout}, 8'd0);
        rd_byte("R8", 8'h12);

        // R7 window timeout
        load(15'h1234, 1'b0, 1'b1);
        rd_byte("R7", 8'h12);
        idle(290);
        chk("R7", {7'd0, win_timeout}, 8'd0);
        idle(200);
        chk("R7", {7'd0, win_timeout}, 8'd1);
        chk("R8", {7'd0, xfer_done}, 8'd0);
        rd_byte("R8", 8'h12);
        load(15'h1234, 1'b0, 1'b1);
        chk("R7", {7'd0, win_timeout}, 8'd0);
        ce_n = 1'b1;

        // R9 capture deferred during an active read
        cont_mode = 1'b0; byte_lo = 1'b1;
        load(15'h0A3C, 1'b1, 1'b0);
        @(negedge clk);
        ce_n = 1'b0; rd_n = 1'b0;
        res_mag = 15'h0011;
        @(negedge clk); busy = 1'b1;
        @(negedge clk); busy = 1'b0;
        idle(3);
        chk("R9", data_out, 8'h3C);
        rd_n = 1'b1;
        idle(2);
        rd_byte("R9", 8'h11);
        ce_n = 1'b1;

        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!ended) begin
            ended = 1'b1;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule